// File: doc/BRIEF.md
# Periodic Battery Health Monitor

This block decides when a backup battery is put under load, and it keeps a warning flag that reports a weak battery. It counts a slow timebase tick. After the supply comes up and a recovery delay has passed, it switches a test load onto the battery for a short window. During that window it watches a digital comparator that reports whether the loaded battery has dropped below its trip point. When the battery passes, the next test is scheduled a long interval later. When it fails, an active-low warning output is pulled low.

The warning is sticky. Only a passing test clears it. Losing power does not clear it. While the warning is set, no periodic tests run. Every power-up forces one more test, whether or not the warning is set. If that test passes, the warning is released and the long-interval schedule starts again. A power failure removes the load at the next clock edge and throws away the partial result. The analog load and the comparator sit outside the block.

Top module: `bhm_battery_monitor`

## Requirements
- R1: Synchronous reset drives `load_en` to 0 and `warn_n` to 1, and leaves the block waiting for power.
- R2: Power counts as good only while `supply_ok` is 1 and `power_fail` is 0. While power is not good, `load_en` is 0 and no test starts.
- R3: Once power becomes good, the first test starts after RECOVERY_TICKS ticks. `load_en` rises on the edge that carries the last of those ticks. This forced test runs whether or not the warning is set.
- R4: A test holds `load_en` at 1 for exactly WINDOW_TICKS ticks. It then drops on the edge that carries the last tick of the window.
- R5: After a passing test, the next test starts on the INTERVAL_TICKS-th tick after the window ends.
- R6: `batt_low` is sampled only on edges where `load_en` is 1. A single sample of 1 makes the test fail. A `batt_low` of 1 while the load is off has no effect.
- R7: A failing test drives `warn_n` to 0 on the same edge that ends the window. No further periodic tests run until the next power-up.
- R8: A passing test drives `warn_n` to 1, even if the warning was set before, and the periodic schedule resumes.
- R9: If power stops being good during a window, `load_en` is 0 after the next edge, and the verdict of that window is discarded: `warn_n` keeps its value.
- R10: `warn_n` keeps its value through any period without power. Only a completed test changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase pulse; all durations are counted in these |
| supply_ok | input | 1 | Supervisor reports the main supply within tolerance |
| power_fail | input | 1 | Power failure in progress |
| batt_low | input | 1 | Comparator: loaded battery below trip point |
| load_en | output | 1 | Connects the test load to the battery (registered) |
| warn_n | output | 1 | Active-low battery warning, meant to drive an open-drain pad (registered) |

## Verification
The hardest state to reach is a power-up retest that starts with the warning already set. Reaching it needs a failed window, a stretch of silence in which no test may run, and then a full power cycle. The bench gets there by holding `batt_low` high for one cycle in the middle of a window. It then watches that no load appears for several intervals, drops `supply_ok`, and brings it back. The retest is run both passing and failing. A power failure is also raised in the middle of a window while `batt_low` is high, to show that the partial result is dropped. Window and interval lengths are swept over three tick spacings.

// File: rtl/bhm_pkg.sv
package bhm_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_RECOVER = 3'd1,
    ST_IDLE    = 3'd2,
    ST_TEST    = 3'd3,
    ST_HOLD    = 3'd4
  } bhm_state_e;

endpackage

// File: rtl/bhm_tick_counter.sv
module bhm_tick_counter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done
);

  logic [CW-1:0] cnt;

  assign done = tick && (cnt == limit - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (tick)    cnt <= cnt + CW'(1);
  end

  // R4: the count never passes the limit of the phase in progress
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    !clear |-> (cnt < limit));

endmodule

// File: rtl/bhm_sequencer.sv
module bhm_sequencer
  import bhm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_good,
  input  logic       done,
  input  logic       verdict_fail,
  output bhm_state_e state,
  output logic       clear,
  output logic       test_end,
  output logic       load_en
);

  bhm_state_e state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      ST_OFF:     if (pwr_good) state_nx = ST_RECOVER;
      ST_RECOVER: if (!pwr_good) state_nx = ST_OFF;
                  else if (done) state_nx = ST_TEST;
      ST_TEST:    if (!pwr_good) state_nx = ST_OFF;
                  else if (done) state_nx = verdict_fail ? ST_HOLD : ST_IDLE;
      ST_IDLE:    if (!pwr_good) state_nx = ST_OFF;
                  else if (done) state_nx = ST_TEST;
      ST_HOLD:    if (!pwr_good) state_nx = ST_OFF;
      default:    state_nx = ST_OFF;
    endcase
  end

  assign test_end = (state == ST_TEST) && pwr_good && done;
  assign clear    = (state_nx != state) || (state == ST_OFF) || (state == ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_OFF;
      load_en <= 1'b0;
    end else begin
      state   <= state_nx;
      load_en <= (state_nx == ST_TEST);
    end
  end

  // R2: no load while power is bad
  a_r2_no_load_unpowered: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> !load_en);

  // R9: a window in progress is torn down at the next edge on power loss
  a_r9_abort_drops_load: assert property (@(posedge clk) disable iff (rst)
    (load_en && !pwr_good) |=> (state == ST_OFF));

  // R7: a failed battery stays parked while power remains good
  a_r7_hold_sticks: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && pwr_good) |=> (state == ST_HOLD && !load_en));

endmodule

// File: rtl/bhm_warn_latch.sv
module bhm_warn_latch (
  input  logic clk,
  input  logic rst,
  input  logic load_en,
  input  logic batt_low,
  input  logic test_end,
  output logic verdict_fail,
  output logic warn_n
);

  logic fail_seen;

  assign verdict_fail = fail_seen || batt_low;

  always_ff @(posedge clk) begin
    if (rst || !load_en)  fail_seen <= 1'b0;
    else if (batt_low)    fail_seen <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)           warn_n <= 1'b1;
    else if (test_end) warn_n <= ~verdict_fail;
  end

  // R10: the warning only moves as a window closes
  a_r10_warn_moves_at_window_end: assert property (@(posedge clk) disable iff (rst)
    !$stable(warn_n) |-> ($past(load_en) && !load_en));

  // R6: a low sample taken under load is never lost before the window closes
  a_r6_low_sample_kept: assert property (@(posedge clk) disable iff (rst)
    (load_en && batt_low && !test_end) |=> (fail_seen || !load_en));

endmodule

// File: rtl/bhm_battery_monitor.sv
module bhm_battery_monitor
  import bhm_pkg::*;
#(
  parameter int unsigned INTERVAL_TICKS = 86_400_000,
  parameter int unsigned WINDOW_TICKS   = 1000,
  parameter int unsigned RECOVERY_TICKS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic supply_ok,
  input  logic power_fail,
  input  logic batt_low,
  output logic load_en,
  output logic warn_n
);

  localparam int unsigned MAX_A = (INTERVAL_TICKS > WINDOW_TICKS) ? INTERVAL_TICKS : WINDOW_TICKS;
  localparam int unsigned MAX_L = (MAX_A > RECOVERY_TICKS) ? MAX_A : RECOVERY_TICKS;
  localparam int unsigned CW    = $clog2(MAX_L + 1);

  bhm_state_e    state;
  logic          pwr_good;
  logic          clear;
  logic          done;
  logic          test_end;
  logic          verdict_fail;
  logic [CW-1:0] limit;

  assign pwr_good = supply_ok && !power_fail;

  always_comb begin
    case (state)
      ST_RECOVER: limit = CW'(RECOVERY_TICKS);
      ST_TEST:    limit = CW'(WINDOW_TICKS);
      default:    limit = CW'(INTERVAL_TICKS);
    endcase
  end

  bhm_tick_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clear (clear),
    .tick  (tick),
    .limit (limit),
    .done  (done)
  );

  bhm_sequencer u_seq (
    .clk          (clk),
    .rst          (rst),
    .pwr_good     (pwr_good),
    .done         (done),
    .verdict_fail (verdict_fail),
    .state        (state),
    .clear        (clear),
    .test_end     (test_end),
    .load_en      (load_en)
  );

  bhm_warn_latch u_warn (
    .clk          (clk),
    .rst          (rst),
    .load_en      (load_en),
    .batt_low     (batt_low),
    .test_end     (test_end),
    .verdict_fail (verdict_fail),
    .warn_n       (warn_n)
  );

  // R8: a warning clears only where a window closes
  a_r8_clear_at_window_end: assert property (@(posedge clk) disable iff (rst)
    $rose(warn_n) |-> $past(load_en));

endmodule

// File: tb/sim_bhm_battery_monitor.sv
module sim_bhm_battery_monitor;

  localparam int IV = 6;
  localparam int WN = 3;
  localparam int RC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic supply_ok = 1'b0;
  logic power_fail = 1'b0;
  logic batt_low = 1'b0;
  logic load_en, warn_n;

  int n_total = 0;
  int n_fail  = 0;
  int per = 1;
  int ph  = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  bhm_battery_monitor #(.INTERVAL_TICKS(IV), .WINDOW_TICKS(WN), .RECOVERY_TICKS(RC)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .supply_ok(supply_ok),
    .power_fail(power_fail), .batt_low(batt_low), .load_en(load_en), .warn_n(warn_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    ph   = (ph + 1) % per;
    tick = (ph == 0);
  endtask

  task automatic wait_load_high(output int n);
    n = 0;
    do begin step(); n++; end while (!load_en && n < 300);
  endtask

  task automatic count_while(input logic lvl, output int n);
    n = 1;
    step();
    while (load_en == lvl && n < 300) begin n++; step(); end
  endtask

  task automatic power_cycle();
    supply_ok = 1'b0;
    repeat (4) step();
    supply_ok = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    int n;
    int highs;
    repeat (3) step();
    rst = 1'b0;
    step();
    chk("R1 load after reset", load_en, 0);
    chk("R1 warn after reset", warn_n, 1);
    repeat (5) step();
    chk("R2 no load without supply", load_en, 0);

    // R3: recovery delay from power-up
    supply_ok = 1'b1;
    wait_load_high(n);
    chk("R3 recovery delay", n, RC + 1);

    // R4/R5 sweep over tick spacing
    for (int p = 1; p <= 3; p++) begin
      supply_ok = 1'b0;
      repeat (3) step();
      per = p; ph = 0; tick = (per == 1);
      supply_ok = 1'b1;
      wait_load_high(n);
      count_while(1'b1, n);
      chk("R4 window length", n, WN * p);
      count_while(1'b0, n);
      chk("R5 interval length", n, IV * p);
      count_while(1'b1, n);
      chk("R4 second window length", n, WN * p);
      chk("R8 warn clear after pass", warn_n, 1);
    end

    // R6/R7: single low sample in a window
    per = 1; ph = 0; tick = 1'b1;
    wait_load_high(n);
    step();
    batt_low = 1'b1; step(); batt_low = 1'b0;
    while (load_en) step();
    chk("R7 warn set by low sample", warn_n, 0);
    highs = 0;
    for (int i = 0; i < 3 * IV; i++) begin step(); if (load_en) highs++; end
    chk("R7 no periodic test while warned", highs, 0);

    // R10 warning kept over power loss, R3 forced retest, R8 clear
    supply_ok = 1'b0;
    repeat (5) step();
    chk("R10 warn kept without power", warn_n, 0);
    chk("R2 no load without power", load_en, 0);
    supply_ok = 1'b1;
    wait_load_high(n);
    chk("R3 retest despite warning", n, RC + 1);
    count_while(1'b1, n);
    chk("R8 retest pass clears warn", warn_n, 1);
    count_while(1'b0, n);
    chk("R8 periodic schedule resumes", n, IV);

    // R9: power fail mid-window with a low sample
    step();
    batt_low = 1'b1; power_fail = 1'b1;
    step();
    chk("R9 load dropped at power fail", load_en, 0);
    batt_low = 1'b0;
    repeat (3) step();
    chk("R9 verdict discarded", warn_n, 1);
    power_fail = 1'b0;
    wait_load_high(n);
    chk("R3 retest after power fail", n, RC + 1);

    // R6: low comparator outside the window is ignored
    count_while(1'b1, n);
    batt_low = 1'b1;
    repeat (IV - 2) step();
    chk("R6 still idle", load_en, 0);
    batt_low = 1'b0;
    wait_load_high(n);
    count_while(1'b1, n);
    chk("R6 outside sample ignored", warn_n, 1);

    // R7: failing retest keeps warning and blocks periodic tests
    wait_load_high(n);
    batt_low = 1'b1;
    while (load_en) step();
    batt_low = 1'b0;
    chk("R7 warn set by full low window", warn_n, 0);
    power_cycle();
    wait_load_high(n);
    chk("R3 retest with warning set", n, RC + 1);
    batt_low = 1'b1;
    while (load_en) step();
    batt_low = 1'b0;
    chk("R7 failed retest keeps warn", warn_n, 0);
    highs = 0;
    for (int i = 0; i < 2 * IV; i++) begin step(); if (load_en) highs++; end
    chk("R7 schedule stays stopped", highs, 0);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule